// File: doc/BRIEF.md
# Legacy I/O Configuration Port Controller

This block is the configuration front end of a multi-function legacy I/O controller. Software reaches it through two byte-wide I/O ports: an index port and a data port. After reset the block is locked. A fixed four-byte key written to the index port opens configuration mode. Software then writes a register number to the index port and moves data through the data port.

Register 0x07 holds the logical device number. It picks which of eight per-device register banks the accesses from 0x30 upward reach. Registers below 0x30 form one global bank that all devices share. Register 0x30 of each device is its activate register, and bit 0 of that register drives the device's enable output. A typical use is to open the port, select device 3 (the parallel port function), clear its activate register so the resource it held is free, dump the bank to confirm, and write 0xAA to close the port.

The host side is a plain synchronous strobe interface: address, write strobe, read strobe, write data. Read data is registered.

Top module: `legacy_cfg_port`

## Requirements
- R1: The index port is at I/O address 0x2E and the data port is at 0x2F. Strobes at any other address change no state, and a read there returns 0xFF.
- R2: Configuration mode opens only after 0x87, 0x01, 0x55 and 0x55 are written to the index port in that order. `cfg_open` rises on the clock edge that takes the fourth byte.
- R3: While locked, an index-port byte that does not match the expected key byte sends the matcher back to waiting for the first key byte. The mismatching byte is not counted as a key byte, so an interrupted or partial key never opens the block.
- R4: While locked, data-port writes are ignored. Reads of either port return 0xFF.
- R5: While open, writing 0xAA to the index port locks the block and does not change the stored index. Any other byte written to the index port becomes the current index.
- R6: Register 0x07 holds the device number in its low 3 bits. Upper write bits are dropped, and the register reads back with its upper bits zero.
- R7: Indices 0x00 to 0x2F, other than 0x07, are global registers that read the same for every device number. Indices 0x30 to 0x3F are stored separately for each of the 8 devices.
- R8: Bit 0 of register 0x30 of device n alone drives `dev_en[n]`, so writing 0x00 there disables device n. The other bits of 0x30 are stored and read back unchanged.
- R9: After reset, every device's register 0x30 reads 0x01, `dev_en` is all ones, the device number is 0, all other registers are 0, and the block is locked.
- R10: `io_rdata` loads on the clock edge where `io_rd` is high and holds its value otherwise. While open, an index-port read returns the current index. A data-port access to an index of 0x40 or above reads 0xFF, and a write there is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 16 | I/O address of the current strobe |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Registered read data |
| cfg_open | output | 1 | High while configuration mode is open |
| dev_en | output | 8 | Per-device enable, bit n from device n register 0x30 bit 0 |

## Verification
On every cycle, the assertions check several rules. `cfg_open` can only rise on an index write of the last key byte. 0xAA always closes an open port. While locked, the enables stay frozen and reads return 0xFF. The banks and global registers change only on a write strobe. `io_rdata` holds between reads. Each enable matches the bit 0 of the byte last written to that device's activate register. The bench scenarios show what a property cannot. These are the exact orderings of interrupted and partial keys, that a write lands in the bank of the selected device and no other, that global registers are shared across device numbers, the truncation of the device number, and the read-back values of a full configure-and-lock session.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam logic [7:0] EXIT_BYTE = 8'hAA;
    localparam logic [7:0] LDN_INDEX = 8'h07;
    localparam logic [7:0] IDLE_READ = 8'hFF;

    // Ordered unlock key; position i of the key sequence.
    function automatic logic [7:0] key_byte(input int unsigned pos);
        case (pos)
            0:       key_byte = 8'h87;
            1:       key_byte = 8'h01;
            2:       key_byte = 8'h55;
            default: key_byte = 8'h55;
        endcase
    endfunction

endpackage

// File: rtl/cfg_key_seq.sv
module cfg_key_seq
    import cfgport_pkg::*;
#(
    parameter int KEY_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       open_o
);
    localparam int STEP_W = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              open;
    } key_state_t;

    key_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (idx_wr) begin
            if (st_q.open) begin
                if (wdata == EXIT_BYTE) begin
                    st_d.open = 1'b0;
                    st_d.step = '0;
                end
            end else if (wdata == key_byte(int'(st_q.step))) begin
                if (int'(st_q.step) == KEY_LEN - 1) begin
                    st_d.open = 1'b1;
                    st_d.step = '0;
                end else begin
                    st_d.step = st_q.step + 1'b1;
                end
            end else begin
                // broken sequence: start over, this byte is not a key byte
                st_d.step = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o = st_q.open;

    p_open_needs_last_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(idx_wr && wdata == key_byte(KEY_LEN - 1)));

    p_no_open_without_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_o && !idx_wr) |=> !open_o);

    p_exit_locks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && idx_wr && wdata == EXIT_BYTE) |=> !open_o);

endmodule

// File: rtl/cfg_glob_regs.sv
module cfg_glob_regs #(
    parameter int NREG = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [$clog2(NREG)-1:0] addr,
    input  logic [7:0]              wdata,
    output logic [7:0]              rdata
);
    typedef struct packed {
        logic [NREG-1:0][7:0] regs;
    } glob_state_t;

    glob_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr && int'(addr) == i) st_d.regs[i] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NREG; i++) begin
            if (int'(addr) == i) rdata = st_q.regs[i];
        end
    end

    p_glob_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(st_q.regs));

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank #(
    parameter int NREG = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [$clog2(NREG)-1:0] off,
    input  logic [7:0]              wdata,
    output logic [7:0]              rdata,
    output logic                    en_o
);
    localparam logic [7:0] ACT_RESET = 8'h01;

    typedef struct packed {
        logic [NREG-1:0][7:0] regs;
    } bank_state_t;

    bank_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr && int'(off) == i) st_d.regs[i] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.regs[0] <= ACT_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = 8'h00;
        for (int i = 0; i < NREG; i++) begin
            if (int'(off) == i) rdata = st_q.regs[i];
        end
    end

    // activate register is offset 0; only its bit 0 enables the device
    assign en_o = st_q.regs[0][0];

    p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(st_q.regs));

    p_en_follows_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && off == '0) |=> (en_o == $past(wdata[0])));

endmodule

// File: rtl/legacy_cfg_port.sv
module legacy_cfg_port
    import cfgport_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [15:0]     IDX_ADDR  = 16'h002E,
    parameter logic [15:0]     DAT_ADDR  = 16'h002F,
    parameter int              NDEV      = 8,
    parameter int              GLOB_REGS = 48,
    parameter int              BANK_BASE = 48,
    parameter int              BANK_REGS = 16,
    parameter int              KEY_LEN   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              cfg_open,
    output logic [NDEV-1:0]   dev_en
);
    localparam int LDN_W  = (NDEV > 1) ? $clog2(NDEV) : 1;
    localparam int OFF_W  = $clog2(BANK_REGS);
    localparam int GOFF_W = $clog2(GLOB_REGS);
    localparam int BANK_END = BANK_BASE + BANK_REGS;

    typedef struct packed {
        logic [7:0]       idx;
        logic [LDN_W-1:0] ldn;
        logic [7:0]       rdata;
    } top_state_t;

    top_state_t st_d, st_q;

    logic              idx_hit, dat_hit, idx_wr, dat_wr;
    logic              is_ldn, is_glob, is_bank;
    logic              glob_wr;
    logic [7:0]        glob_rd;
    logic [OFF_W-1:0]  bank_off;
    logic [NDEV-1:0]   bank_wr;
    logic [7:0]        bank_rd [NDEV];
    logic [7:0]        sel_bank_rd;
    logic [7:0]        rd_val;

    assign idx_hit = (io_addr == ADDR_W'(IDX_ADDR));
    assign dat_hit = (io_addr == ADDR_W'(DAT_ADDR));
    assign idx_wr  = io_wr && idx_hit;
    assign dat_wr  = io_wr && dat_hit && cfg_open;

    assign is_ldn  = (st_q.idx == LDN_INDEX);
    assign is_glob = !is_ldn && (int'(st_q.idx) < GLOB_REGS) && (int'(st_q.idx) < BANK_BASE);
    assign is_bank = (int'(st_q.idx) >= BANK_BASE) && (int'(st_q.idx) < BANK_END);
    assign glob_wr = dat_wr && is_glob;
    assign bank_off = OFF_W'(int'(st_q.idx) - BANK_BASE);

    cfg_key_seq #(.KEY_LEN(KEY_LEN)) u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (idx_wr),
        .wdata  (io_wdata),
        .open_o (cfg_open)
    );

    cfg_glob_regs #(.NREG(GLOB_REGS)) u_glob (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (glob_wr),
        .addr  (st_q.idx[GOFF_W-1:0]),
        .wdata (io_wdata),
        .rdata (glob_rd)
    );

    for (genvar d = 0; d < NDEV; d++) begin : g_dev
        assign bank_wr[d] = dat_wr && is_bank && (st_q.ldn == LDN_W'(d));

        cfg_dev_bank #(.NREG(BANK_REGS)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (bank_wr[d]),
            .off   (bank_off),
            .wdata (io_wdata),
            .rdata (bank_rd[d]),
            .en_o  (dev_en[d])
        );
    end

    always_comb begin
        sel_bank_rd = 8'h00;
        for (int d = 0; d < NDEV; d++) begin
            if (st_q.ldn == LDN_W'(d)) sel_bank_rd = bank_rd[d];
        end
    end

    always_comb begin
        rd_val = IDLE_READ;
        if (cfg_open) begin
            if (idx_hit) begin
                rd_val = st_q.idx;
            end else if (dat_hit) begin
                if (is_ldn)       rd_val = 8'(st_q.ldn);
                else if (is_glob) rd_val = glob_rd;
                else if (is_bank) rd_val = sel_bank_rd;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (idx_wr && cfg_open && io_wdata != EXIT_BYTE) st_d.idx = io_wdata;
        if (dat_wr && is_ldn) st_d.ldn = io_wdata[LDN_W-1:0];
        if (io_rd) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign io_rdata = st_q.rdata;

    p_locked_read_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_rd) |=> (io_rdata == IDLE_READ));

    p_locked_en_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> $stable(dev_en));

    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));

    p_one_bank_written_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_wr));

    p_exit_keeps_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && io_wdata == EXIT_BYTE) |=> $stable(st_q.idx));

endmodule

// File: tb/legacy_cfg_port_test.sv
module legacy_cfg_port_test;

    localparam logic [15:0] IDX = 16'h002E;
    localparam logic [15:0] DAT = 16'h002F;

    typedef struct packed {
        logic       wr;
        logic [2:0] dev;
        logic [7:0] idx;
        logic [7:0] dat;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 3'd0, 8'h30, 8'h00, 8'h01, 4'd9},   // R9 activate reset value
        '{1'b1, 3'd3, 8'h30, 8'h00, 8'h00, 4'd8},   // R8 disable device 3
        '{1'b0, 3'd3, 8'h30, 8'h00, 8'h00, 4'd8},
        '{1'b1, 3'd3, 8'h30, 8'hA4, 8'h00, 4'd8},   // R8 upper bits stored
        '{1'b0, 3'd3, 8'h30, 8'h00, 8'hA4, 4'd8},
        '{1'b1, 3'd2, 8'h31, 8'h5A, 8'h00, 4'd7},   // R7 banked write
        '{1'b0, 3'd2, 8'h31, 8'h00, 8'h5A, 4'd7},
        '{1'b0, 3'd1, 8'h31, 8'h00, 8'h00, 4'd7},   // R7 other bank untouched
        '{1'b1, 3'd1, 8'h20, 8'hC3, 8'h00, 4'd7},   // R7 global write
        '{1'b0, 3'd6, 8'h20, 8'h00, 8'hC3, 4'd7},
        '{1'b0, 3'd7, 8'h07, 8'h00, 8'h07, 4'd6},   // R6 readback
        '{1'b1, 3'd4, 8'h45, 8'h77, 8'h00, 4'd10},  // R10 out of range write
        '{1'b0, 3'd4, 8'h45, 8'h00, 8'hFF, 4'd10},
        '{1'b0, 3'd4, 8'h3F, 8'h00, 8'h00, 4'd9}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        cfg_open;
    logic [7:0]  dev_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    legacy_cfg_port uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .io_wdata (io_wdata),
        .io_rdata (io_rdata),
        .cfg_open (cfg_open),
        .dev_en   (dev_en)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        d = io_rdata;
    endtask

    task automatic unlock();
        io_write(IDX, 8'h87); io_write(IDX, 8'h01);
        io_write(IDX, 8'h55); io_write(IDX, 8'h55);
    endtask

    task automatic set_reg(input logic [2:0] dev, input logic [7:0] i, input logic [7:0] d);
        io_write(IDX, 8'h07); io_write(DAT, {5'b0, dev});
        io_write(IDX, i);     io_write(DAT, d);
    endtask

    task automatic get_reg(input logic [2:0] dev, input logic [7:0] i, output logic [7:0] d);
        io_write(IDX, 8'h07); io_write(DAT, {5'b0, dev});
        io_write(IDX, i);     io_read(DAT, d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        check("R9 open after reset", {7'b0, cfg_open}, 8'h00);
        check("R9 dev_en after reset", dev_en, 8'hFF);
        // R4 locked reads
        io_read(DAT, r); check("R4 locked data read", r, 8'hFF);
        io_read(IDX, r); check("R4 locked index read", r, 8'hFF);
        // R4 locked data write ignored
        io_write(DAT, 8'h00);
        check("R4 locked write ignored", dev_en, 8'hFF);

        // R3 partial and broken keys
        io_write(IDX, 8'h87); io_write(IDX, 8'h01); io_write(IDX, 8'h55);
        io_write(IDX, 8'h00);
        io_write(IDX, 8'h55);
        check("R3 broken key stays locked", {7'b0, cfg_open}, 8'h00);
        io_write(IDX, 8'h87); io_write(IDX, 8'h01); io_write(IDX, 8'h87);
        io_write(IDX, 8'h01); io_write(IDX, 8'h55); io_write(IDX, 8'h55);
        check("R3 restart byte not counted", {7'b0, cfg_open}, 8'h00);

        // R1 key on the data port does nothing
        io_write(DAT, 8'h87); io_write(DAT, 8'h01);
        io_write(DAT, 8'h55); io_write(DAT, 8'h55);
        check("R1 key on data port", {7'b0, cfg_open}, 8'h00);

        // R2 full key opens on the fourth write
        io_write(IDX, 8'h87); io_write(IDX, 8'h01); io_write(IDX, 8'h55);
        check("R2 open before last byte", {7'b0, cfg_open}, 8'h00);
        io_write(IDX, 8'h55);
        check("R2 open after key", {7'b0, cfg_open}, 8'h01);

        // vector table walk
        for (int v = 0; v < NVEC; v++) begin
            if (VECS[v].wr) begin
                set_reg(VECS[v].dev, VECS[v].idx, VECS[v].dat);
            end else begin
                get_reg(VECS[v].dev, VECS[v].idx, r);
                check($sformatf("R%0d vector %0d", VECS[v].req, v), r, VECS[v].exp);
            end
        end

        // R8 enable follows bit 0 only
        check("R8 device 3 disabled", dev_en, 8'hF7);
        set_reg(3'd3, 8'h30, 8'h01);
        check("R8 device 3 re-enabled", dev_en, 8'hFF);

        // R6 device number truncation and bank select
        io_write(IDX, 8'h07); io_write(DAT, 8'hFB);
        io_read(DAT, r); check("R6 device number truncated", r, 8'h03);
        io_write(IDX, 8'h30); io_read(DAT, r);
        check("R6 bank of device 3", r, 8'h01);

        // R10 index port readback and hold
        io_read(IDX, r); check("R10 index readback", r, 8'h30);
        repeat (3) @(negedge clk);
        check("R10 rdata holds", io_rdata, 8'h30);
        io_read(16'h0080, r); check("R1 other address read", r, 8'hFF);

        // R5 exit and locked behaviour afterwards
        io_write(IDX, 8'hAA);
        check("R5 locked after exit", {7'b0, cfg_open}, 8'h00);
        io_read(DAT, r); check("R5 data read after exit", r, 8'hFF);
        io_write(DAT, 8'h00);
        check("R4 write after exit ignored", dev_en, 8'hFF);
        unlock();
        io_read(IDX, r); check("R5 index kept across exit", r, 8'h30);
        io_read(DAT, r); check("R4 activate unchanged while locked", r, 8'h01);

        // R9 reset mid-run
        set_reg(3'd5, 8'h30, 8'h00);
        check("R8 device 5 disabled", dev_en, 8'hDF);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R9 dev_en after second reset", dev_en, 8'hFF);
        check("R9 locked after second reset", {7'b0, cfg_open}, 8'h00);
        unlock();
        io_write(IDX, 8'h07); io_read(DAT, r);
        check("R9 device number reset", r, 8'h00);
        get_reg(3'd2, 8'h31, r); check("R9 bank cleared", r, 8'h00);

        finish_run();
    end

endmodule